// File: doc/BRIEF.md
# BT.656 Embedded Sync Decoder

This block sits on an 8-bit video byte stream that arrives one byte per pixel clock. The stream carries no sync pins. Line and frame timing are recovered from four-byte timing reference codes that the source embeds in the stream. Every code starts with the preamble FF 00 00 and ends with a status byte. A status byte of 80 opens the active part of a line. A status byte of 9D closes it. The block pulses an event output for each code. It passes on only the bytes that lie between an opening and a closing code, with a data-valid flag. It also raises a frame-start pulse once the stream has shown vertical blanking.

A short delay line sits between the input and the data output. A closing code only becomes known on its fourth byte. By then its three preamble bytes have already been accepted as candidate data, so they must be removed before they reach the output. The event pulses do not wait for this line: each appears in the cycle after the status byte is sampled. A blanking line is a line that ends with a closing code and has no opening code before the next closing code. The first opening code after such a line starts a new frame.

Top module: `bt656_sync_decoder`

## Requirements
- R1: While `rst_n` is low, `vid_vld_o`, `sav_o`, `eav_o` and `sof_o` are 0.
- R2: When the bytes FF, 00, 00, 80 are sampled on four consecutive rising edges, `sav_o` is 1 for exactly the one cycle after the edge that samples 80.
- R3: When the bytes FF, 00, 00, 9D are sampled on four consecutive rising edges, `eav_o` is 1 for exactly the one cycle after the edge that samples 9D.
- R4: A byte sampled after an opening code and before the next closing code appears on `vid_o` with `vid_vld_o` = 1 in the cycle after the third rising edge that follows its own sampling edge.
- R5: Bytes sampled after a closing code and before the next opening code never produce `vid_vld_o` = 1, even when their value is 80 or 9D.
- R6: The status byte of any code, and the FF 00 00 preamble of a closing code, never produce `vid_vld_o` = 1.
- R7: If the byte after FF is not 00, or the byte after FF 00 is not 00, or the status byte is neither 80 nor 9D, no event pulse is produced. Inside the active region, those bytes stay valid data.
- R8: An FF received at any point in the search restarts it. This covers FF FF 00 00 80 and FF 00 FF 00 00 9D, and both are still detected as codes.
- R9: `sof_o` is 1 together with `sav_o` only for the first opening code after a blanking line. Before a blanking line has been seen since reset, `sof_o` stays 0.
- R10: After `sof_o` has fired, it stays 0 for every later opening code until a new blanking line has been seen. A line with a single closing code does not count as a blanking line.
- R11: `sav_o` and `eav_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; one byte per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_i | input | 8 | Incoming video byte stream |
| vid_o | output | 8 | Delayed video byte |
| vid_vld_o | output | 1 | High when `vid_o` holds active video data |
| sav_o | output | 1 | One-cycle pulse on an opening code |
| eav_o | output | 1 | One-cycle pulse on a closing code |
| sof_o | output | 1 | One-cycle pulse on the first opening code after a blanking line |

## Verification
A matcher stuck in the wrong state shows up as a missing or extra event pulse in the cycle right after the status byte. A wrong active flag shows up three cycles later, as blanking bytes marked valid or active bytes dropped. A fault in the preamble clearing can be seen only on the three output cycles that line up with a closing code's preamble. A wrong blanking-line tracker becomes visible only at the next opening code, because `sof_o` appears there when it should not or stays low when it should fire. That can be a whole line or more after the fault.

// File: rtl/bt656_sync_decoder.sv
module bt656_sync_decoder #(
  parameter logic [7:0] SAV_STAT = 8'h80,
  parameter logic [7:0] EAV_STAT = 8'h9D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] vid_i,
  output logic [7:0] vid_o,
  output logic       vid_vld_o,
  output logic       sav_o,
  output logic       eav_o,
  output logic       sof_o
);
  localparam int DLY = 4;

  typedef enum logic [1:0] {SRCH, G_FF, G_Z1, G_Z2} mst_t;

  mst_t st, st_nxt;
  logic active, seen_eav, blank_ok;
  logic [7:0] dq [DLY];
  logic [DLY-1:0] vq;

  wire hit_sav = (st == G_Z2) && (vid_i == SAV_STAT);
  wire hit_eav = (st == G_Z2) && (vid_i == EAV_STAT);
  wire hit     = hit_sav | hit_eav;

  always_comb begin
    st_nxt = SRCH;
    if (vid_i == 8'hFF) st_nxt = G_FF;
    else if (vid_i == 8'h00) begin
      case (st)
        G_FF:    st_nxt = G_Z1;
        G_Z1:    st_nxt = G_Z2;
        default: st_nxt = SRCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SRCH;
      active   <= 1'b0;
      seen_eav <= 1'b0;
      blank_ok <= 1'b0;
      sav_o    <= 1'b0;
      eav_o    <= 1'b0;
      sof_o    <= 1'b0;
      vq       <= '0;
      for (int i = 0; i < DLY; i++) dq[i] <= '0;
    end else begin
      st    <= st_nxt;
      sav_o <= hit_sav;
      eav_o <= hit_eav;
      sof_o <= hit_sav & blank_ok;
      if (hit_sav) begin
        active   <= 1'b1;
        seen_eav <= 1'b0;
        blank_ok <= 1'b0;
      end
      if (hit_eav) begin
        active   <= 1'b0;
        seen_eav <= 1'b1;
        if (seen_eav) blank_ok <= 1'b1;
      end
      dq[0] <= vid_i;
      vq[0] <= active & ~hit;
      for (int i = 1; i < DLY; i++) begin
        dq[i] <= dq[i-1];
        vq[i] <= vq[i-1] & ~hit;
      end
    end
  end

  assign vid_o     = dq[DLY-1];
  assign vid_vld_o = vq[DLY-1];
endmodule

module bt656_sync_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic vid_vld_o,
  input logic sav_o,
  input logic eav_o,
  input logic sof_o
);
  // R11
  ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(sav_o && eav_o));
  // R2
  sav_single_chk: assert property (@(posedge clk) disable iff (!rst_n) sav_o |=> !sav_o);
  // R3
  eav_single_chk: assert property (@(posedge clk) disable iff (!rst_n) eav_o |=> !eav_o);
  // R9
  sof_with_sav_chk: assert property (@(posedge clk) disable iff (!rst_n) sof_o |-> sav_o);
  // R6
  eav_pre0_chk: assert property (@(posedge clk) disable iff (!rst_n) eav_o |-> !vid_vld_o);
  // R6
  eav_pre1_chk: assert property (@(posedge clk) disable iff (!rst_n) eav_o |=> !vid_vld_o);
  // R6
  eav_pre2_chk: assert property (@(posedge clk) disable iff (!rst_n) eav_o |-> ##2 !vid_vld_o);
  // R6
  eav_stat_chk: assert property (@(posedge clk) disable iff (!rst_n) eav_o |-> ##3 !vid_vld_o);
  // R6
  sav_pre_chk: assert property (@(posedge clk) disable iff (!rst_n) sav_o |-> !vid_vld_o);
endmodule

bind bt656_sync_decoder bt656_sync_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vid_vld_o(vid_vld_o),
  .sav_o(sav_o), .eav_o(eav_o), .sof_o(sof_o)
);

// File: tb/bt656_sync_decoder_tb_top.sv
module bt656_sync_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] vid_i = 8'h00;
  logic [7:0] vid_o;
  logic vid_vld_o, sav_o, eav_o, sof_o;

  always #2 clk = ~clk;

  bt656_sync_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .vid_i(vid_i), .vid_o(vid_o),
    .vid_vld_o(vid_vld_o), .sav_o(sav_o), .eav_o(eav_o), .sof_o(sof_o)
  );

  typedef struct {
    logic [7:0] b;
    bit v, s, e, f;
    string tag;
  } item_t;

  item_t q[$];
  item_t hist[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic put(input logic [7:0] b, input bit v, input bit s, input bit e,
                     input bit f, input string tag);
    @(negedge clk);
    vid_i = b;
    q.push_back('{b, v, s, e, f, tag});
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) put((i % 2) ? 8'h80 : 8'h9D, 0, 0, 0, 0, "R5");
  endtask

  task automatic act(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) put(base + 8'(i), 1, 0, 0, 0, "R4");
  endtask

  task automatic sav(input bit f);
    put(8'hFF, 0, 0, 0, 0, "R6");
    put(8'h00, 0, 0, 0, 0, "R6");
    put(8'h00, 0, 0, 0, 0, "R6");
    put(8'h80, 0, 1, 0, f, f ? "R9" : "R10");
  endtask

  task automatic eav();
    put(8'hFF, 0, 0, 0, 0, "R6");
    put(8'h00, 0, 0, 0, 0, "R6");
    put(8'h00, 0, 0, 0, 0, "R6");
    put(8'h9D, 0, 0, 1, 0, "R3");
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        item_t it, old;
        it = q.pop_front();
        chk(sav_o == it.s, it.tag, "sav_o", sav_o, it.s);
        chk(eav_o == it.e, it.tag, "eav_o", eav_o, it.e);
        chk(sof_o == it.f, it.tag, "sof_o", sof_o, it.f);
        hist.push_back(it);
        if (hist.size() == 4) begin
          old = hist.pop_front();
          chk(vid_vld_o == old.v, old.tag, "vid_vld_o", vid_vld_o, old.v);
          if (old.v) chk(vid_o == old.b, old.tag, "vid_o", vid_o, old.b);
        end
      end
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    chk(!vid_vld_o && !sav_o && !eav_o && !sof_o, "R1", "outputs in reset",
        {vid_vld_o, sav_o, eav_o, sof_o}, 0);
    vid_i = 8'hFF;
    @(negedge clk);
    chk(!vid_vld_o && !sav_o && !eav_o && !sof_o, "R1", "outputs in reset",
        {vid_vld_o, sav_o, eav_o, sof_o}, 0);
    rst_n = 1'b1;
    blank(6);
    sav(0);                       // R9: no blanking line yet
    act(4, 8'h20);
    eav();
    blank(4);
    eav();                        // blanking line complete
    blank(4);
    sav(1);                       // R9
    put(8'hFF, 1, 0, 0, 0, "R7"); put(8'h01, 1, 0, 0, 0, "R7");
    put(8'hFF, 1, 0, 0, 0, "R7"); put(8'h00, 1, 0, 0, 0, "R7");
    put(8'h02, 1, 0, 0, 0, "R7");
    put(8'hFF, 1, 0, 0, 0, "R7"); put(8'h00, 1, 0, 0, 0, "R7");
    put(8'h00, 1, 0, 0, 0, "R7"); put(8'h55, 1, 0, 0, 0, "R7");
    act(3, 8'h40);
    eav();
    blank(3);
    sav(0);                       // R10: single closing code is no blanking line
    act(3, 8'h60);
    eav();
    put(8'hFF, 0, 0, 0, 0, "R7"); put(8'h00, 0, 0, 0, 0, "R7");
    put(8'h00, 0, 0, 0, 0, "R7"); put(8'h55, 0, 0, 0, 0, "R7");
    put(8'hFF, 0, 0, 0, 0, "R7"); put(8'h00, 0, 0, 0, 0, "R7");
    put(8'h12, 0, 0, 0, 0, "R7");
    put(8'hFF, 0, 0, 0, 0, "R8");
    sav(0);                       // R8: FF FF 00 00 80
    act(2, 8'h70);
    put(8'hFF, 1, 0, 0, 0, "R8"); put(8'h00, 1, 0, 0, 0, "R8");
    eav();                        // R8: FF 00 FF 00 00 9D
    blank(3);
    eav();
    blank(2);
    eav();
    sav(1);                       // R9 after repeated blanking
    act(2, 8'h90);
    eav();
    blank(4);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule